// File: doc/BRIEF.md
# SAR Conversion Timing Controller

This block is the digital control core of a successive-approximation converter. An active-low start strobe, sampled on the master clock, opens a conversion. The core raises BUSY, puts the track/hold into hold and walks a successive-approximation register through one bit per master-clock edge, MSB first. The bits are decided from a single comparator input that the analog side (a stub in simulation) returns for the trial code the core drives. When the last bit is settled the result register is loaded with the converted data and the channel number captured at the start. The track/hold then goes back to track, and BUSY falls on the thirteenth edge after the start edge.

The master clock may be continuous or gated into bursts. All state advances only on its edges, so the core stays frozen when the clock stops and carries on where it left off. A two-bit power mode selects normal operation, full shutdown (no conversions at all) or one of two automatic power-down modes. In the automatic modes the core drops to sleep after each conversion, and a rising start strobe only wakes it. The next falling strobe then converts.

Top module: `sar_conv_ctl`

## Requirements
- R1: With the core idle and awake, the first rising clock edge that samples `conv_n` low after sampling it high is the start edge. BUSY and hold (`th_hold`=1) are high right after it, and `ch_sel` is captured there.
- R2: BUSY stays high for exactly 13 clock edges. It falls on the 13th rising edge after the start edge and is low whenever the core is idle.
- R3: `th_hold` is still high after the 12th edge and is low after the 13th edge, on the same edge BUSY falls and never later.
- R4: Bits are resolved MSB first, one per edge. With the 12-bit default, `dac_code` right after the start edge is 0x800 (only the trial bit set). On each edge the current trial bit is kept when `cmp_in` is 1 and cleared when it is 0, so a comparator that reports `dac_code <= V` yields the code V.
- R5: The result is loaded on the 12th edge, one cycle before BUSY falls. `result` bits 14:12 hold the captured channel and bits 11:0 hold the data. `load_stb` is high for exactly the cycle after that edge.
- R6: A falling start strobe seen while BUSY is high is ignored: the running conversion keeps its timing and no second conversion follows.
- R7: With the master clock stopped, idle or mid-conversion, no output changes. Once the clock resumes, the conversion completes with the correct result after 13 edges in total.
- R8: Power mode 2 or 3 (automatic power-down) puts the core to sleep (`core_awake`=0) on the edge BUSY falls. A rising start strobe wakes it on the edge that samples the rise, without starting a conversion. The next falling strobe starts one.
- R9: Power mode 1 (full shutdown) holds `core_awake` low, and no strobe edge starts a conversion. Mode 0 (normal) clears any sleep state on the next edge.
- R10: While reset is asserted, BUSY, `th_hold`, `load_stb` and `result` are 0 and `core_awake` is 1 (in mode 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master conversion clock, continuous or burst |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| conv_n | input | 1 | Active-low conversion start strobe |
| pwr_mode | input | 2 | 0 normal, 1 full shutdown, 2 auto shutdown, 3 auto standby |
| ch_sel | input | 3 | Channel number stored with the result |
| cmp_in | input | 1 | Comparator decision for the current trial code |
| busy | output | 1 | Conversion in progress |
| th_hold | output | 1 | Track/hold control, 1 = hold |
| dac_code | output | 12 | Trial code presented to the comparator |
| load_stb | output | 1 | One-cycle pulse when the result register is written |
| result | output | 15 | Channel (14:12) and converted data (11:0) |
| core_awake | output | 1 | Core powered and ready for a start strobe |

## Verification
Each result has a fixed slot counted in master-clock edges from the start edge. BUSY and hold are due right after the start edge. The first trial code is due there too. The result and `load_stb` are due after edge 12, and BUSY falling with hold released after edge 13. In the automatic modes, sleep is due after edge 13 and wake after the edge that samples the rising strobe. The bench drives every input on the falling clock edge and reads every output on the next falling edge, counting rising edges in a loop, so each check lands exactly in its slot. The stalled-clock cases are checked by elapsed time with no edges in between.

// File: rtl/sar_ctl_pkg.sv
`timescale 1ns/1ps
package sar_ctl_pkg;

  typedef enum logic [1:0] {
    PM_NORMAL    = 2'd0,
    PM_OFF       = 2'd1,
    PM_AUTO_OFF  = 2'd2,
    PM_AUTO_IDLE = 2'd3
  } pwr_mode_e;

  localparam int unsigned DEF_RES    = 12;
  localparam int unsigned DEF_CYCLES = 13;
  localparam int unsigned DEF_CH_W   = 3;

endpackage

// File: rtl/sar_rst_sync.sv
`timescale 1ns/1ps
module sar_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign srst_n = sync_q;

endmodule

// File: rtl/sar_strobe_edge.sv
`timescale 1ns/1ps
module sar_strobe_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_n,
  output logic fell,
  output logic rose
);

  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= strobe_n;
  end

  assign fell = prev_q & ~strobe_n;
  assign rose = ~prev_q & strobe_n;

endmodule

// File: rtl/sar_power_ctl.sv
`timescale 1ns/1ps
module sar_power_ctl
  import sar_ctl_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  pwr_mode_e mode,
  input  logic      rose,
  input  logic      done,
  output logic      awake
);

  logic sleep_q;
  logic sleep_d;
  logic auto_mode;

  assign auto_mode = (mode == PM_AUTO_OFF) || (mode == PM_AUTO_IDLE);

  always_comb begin
    sleep_d = sleep_q;
    if (mode == PM_NORMAL)         sleep_d = 1'b0;
    else if (auto_mode && done)    sleep_d = 1'b1;
    else if (sleep_q && rose)      sleep_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sleep_q <= 1'b0;
    else        sleep_q <= sleep_d;
  end

  assign awake = (mode != PM_OFF) && !sleep_q;

  p_auto_sleep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_mode && done) |=> !awake);

  p_normal_wakes_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == PM_NORMAL) |=> (sleep_q == 1'b0));

endmodule

// File: rtl/sar_seq_ctr.sv
`timescale 1ns/1ps
module sar_seq_ctr #(
  parameter int unsigned CONV_CYCLES = 13,
  localparam int unsigned CW = $clog2(CONV_CYCLES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          busy,
  output logic          hold,
  output logic [CW-1:0] cnt,
  output logic          done
);

  localparam logic [CW-1:0] LAST_C = CW'(CONV_CYCLES - 1);
  localparam logic [CW-1:0] IDLE_C = CW'(CONV_CYCLES);

  logic          busy_q, busy_d;
  logic          hold_q, hold_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          en;

  assign done = busy_q && (cnt_q == LAST_C);
  assign en   = start || busy_q;

  always_comb begin
    busy_d = busy_q;
    hold_d = hold_q;
    cnt_d  = cnt_q;
    if (start) begin
      busy_d = 1'b1;
      hold_d = 1'b1;
      cnt_d  = '0;
    end else if (done) begin
      busy_d = 1'b0;
      hold_d = 1'b0;
      cnt_d  = IDLE_C;
    end else begin
      cnt_d  = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      hold_q <= 1'b0;
      cnt_q  <= IDLE_C;
    end else if (en) begin
      busy_q <= busy_d;
      hold_q <= hold_d;
      cnt_q  <= cnt_d;
    end
  end

  assign busy = busy_q;
  assign hold = hold_q;
  assign cnt  = cnt_q;

  p_cnt_sat_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= IDLE_C);

  p_idle_cnt_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> (cnt_q == IDLE_C));

  p_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !done) |=> (busy_q && (cnt_q == $past(cnt_q) + CW'(1))));

  p_track_with_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold_q) |-> $fell(busy_q));

endmodule

// File: rtl/sar_approx_reg.sv
`timescale 1ns/1ps
module sar_approx_reg #(
  parameter int unsigned RES         = 12,
  parameter int unsigned CH_W        = 3,
  parameter int unsigned CONV_CYCLES = 13,
  localparam int unsigned CW = $clog2(CONV_CYCLES + 1),
  localparam int unsigned ACQ = CONV_CYCLES - 1 - RES
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               busy,
  input  logic [CW-1:0]      cnt,
  input  logic               cmp_in,
  input  logic [CH_W-1:0]    ch_sel,
  output logic [RES-1:0]     dac_code,
  output logic [CH_W+RES-1:0] result,
  output logic               load_stb
);

  localparam logic [CW-1:0] LAST_RES_C = CW'(ACQ + RES - 1);

  logic [RES-1:0]      sar_q, sar_d;
  logic [CH_W-1:0]     ch_q, ch_d;
  logic [CH_W+RES-1:0] res_q, res_d;
  logic                load_q, load_d;
  logic [RES-1:0]      mask;
  logic                last_bit;
  logic                sar_en;

  always_comb begin
    for (int b = 0; b < RES; b++) begin
      mask[b] = busy && (cnt == CW'(ACQ + RES - 1 - b));
    end
  end

  assign last_bit = busy && (cnt == LAST_RES_C);
  assign sar_en   = start || busy;

  always_comb begin
    sar_d  = sar_q;
    ch_d   = ch_q;
    res_d  = res_q;
    load_d = 1'b0;
    if (start) begin
      sar_d = '0;
      ch_d  = ch_sel;
    end else if (|mask) begin
      if (cmp_in) sar_d = sar_q | mask;
      if (last_bit) begin
        res_d  = {ch_q, sar_d};
        load_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sar_q <= '0;
      ch_q  <= '0;
    end else if (sar_en) begin
      sar_q <= sar_d;
      ch_q  <= ch_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) res_q <= '0;
    else if (last_bit) res_q <= res_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) load_q <= 1'b0;
    else        load_q <= load_d;
  end

  assign dac_code = sar_q | mask;
  assign result   = res_q;
  assign load_stb = load_q;

  p_load_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    load_q |=> !load_q);

  p_bits_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !start) |=> ((sar_q & $past(sar_q)) == $past(sar_q)));

  p_one_trial_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(mask));

endmodule

// File: rtl/sar_conv_ctl.sv
`timescale 1ns/1ps
module sar_conv_ctl
  import sar_ctl_pkg::*;
#(
  parameter int unsigned RES         = DEF_RES,
  parameter int unsigned CH_W        = DEF_CH_W,
  parameter int unsigned CONV_CYCLES = DEF_CYCLES
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                conv_n,
  input  logic [1:0]          pwr_mode,
  input  logic [CH_W-1:0]     ch_sel,
  input  logic                cmp_in,
  output logic                busy,
  output logic                th_hold,
  output logic [RES-1:0]      dac_code,
  output logic                load_stb,
  output logic [CH_W+RES-1:0] result,
  output logic                core_awake
);

  localparam int unsigned CW = $clog2(CONV_CYCLES + 1);

  logic          srst_n;
  logic          fell, rose;
  logic          start;
  logic          done;
  logic [CW-1:0] cnt;
  pwr_mode_e     mode;

  assign mode = pwr_mode_e'(pwr_mode);

  sar_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  sar_strobe_edge u_edge (
    .clk      (clk),
    .rst_n    (srst_n),
    .strobe_n (conv_n),
    .fell     (fell),
    .rose     (rose)
  );

  sar_power_ctl u_pwr (
    .clk   (clk),
    .rst_n (srst_n),
    .mode  (mode),
    .rose  (rose),
    .done  (done),
    .awake (core_awake)
  );

  assign start = fell && !busy && core_awake;

  sar_seq_ctr #(
    .CONV_CYCLES (CONV_CYCLES)
  ) u_seq (
    .clk   (clk),
    .rst_n (srst_n),
    .start (start),
    .busy  (busy),
    .hold  (th_hold),
    .cnt   (cnt),
    .done  (done)
  );

  sar_approx_reg #(
    .RES         (RES),
    .CH_W        (CH_W),
    .CONV_CYCLES (CONV_CYCLES)
  ) u_sar (
    .clk      (clk),
    .rst_n    (srst_n),
    .start    (start),
    .busy     (busy),
    .cnt      (cnt),
    .cmp_in   (cmp_in),
    .ch_sel   (ch_sel),
    .dac_code (dac_code),
    .result   (result),
    .load_stb (load_stb)
  );

  p_load_in_busy_r5: assert property (@(posedge clk) disable iff (!srst_n)
    load_stb |-> (busy && th_hold));

  p_start_needs_awake_r8: assert property (@(posedge clk) disable iff (!srst_n)
    $rose(busy) |-> $past(core_awake));

  p_hold_follows_start_r1: assert property (@(posedge clk) disable iff (!srst_n)
    $rose(busy) |-> th_hold);

endmodule

// File: tb/sar_conv_ctl_test.sv
`timescale 1ns/1ps
module sar_conv_ctl_test;

  logic        clk;
  logic        clk_en;
  logic        rst_n;
  logic        conv_n;
  logic [1:0]  pwr_mode;
  logic [2:0]  ch_sel;
  logic        cmp_in;
  logic        busy;
  logic        th_hold;
  logic [11:0] dac_code;
  logic        load_stb;
  logic [14:0] result;
  logic        core_awake;
  logic [11:0] target;

  int total = 0;
  int bad   = 0;
  bit fin   = 0;

  sar_conv_ctl uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .conv_n     (conv_n),
    .pwr_mode   (pwr_mode),
    .ch_sel     (ch_sel),
    .cmp_in     (cmp_in),
    .busy       (busy),
    .th_hold    (th_hold),
    .dac_code   (dac_code),
    .load_stb   (load_stb),
    .result     (result),
    .core_awake (core_awake)
  );

  // Comparator stub: keep the trial bit when the trial code does not exceed the input.
  assign cmp_in = (dac_code <= target);

  initial clk = 1'b0;
  always #2 if (clk_en) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run_conv(input logic [2:0] ch, input logic [11:0] v,
                          input bit glitch, input bit stall);
    logic [11:0] held;
    @(negedge clk);
    target = v;
    ch_sel = ch;
    conv_n = 1'b0;
    @(negedge clk);
    chk("R1 busy after start edge", busy, 1);
    chk("R1 hold after start edge", th_hold, 1);
    chk("R4 first trial code", dac_code, 12'h800);
    ch_sel = ~ch;
    for (int k = 1; k <= 13; k++) begin
      @(negedge clk);
      if (k < 12) chk("R2 busy during conversion", busy, 1);
      if (k == 12) begin
        chk("R5 load strobe after edge 12", load_stb, 1);
        chk("R5 result contents", result, {ch, v});
        chk("R3 hold before edge 13", th_hold, 1);
        chk("R2 busy before edge 13", busy, 1);
      end
      if (k == 13) begin
        chk("R2 busy low after edge 13", busy, 0);
        chk("R3 track after edge 13", th_hold, 0);
        chk("R5 load strobe one cycle", load_stb, 0);
      end
      if (glitch && k == 4) conv_n = 1'b1;
      if (glitch && k == 5) conv_n = 1'b0;
      if (stall && k == 6) begin
        held   = dac_code;
        clk_en = 1'b0;
        #40;
        chk("R7 busy with clock stopped", busy, 1);
        chk("R7 trial code frozen", dac_code, held);
        clk_en = 1'b1;
      end
    end
    if (glitch) begin
      for (int j = 0; j < 3; j++) begin
        @(negedge clk);
        chk("R6 no second conversion", busy, 0);
      end
    end
  endtask

  task automatic raise_strobe();
    @(negedge clk);
    conv_n = 1'b1;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R10 busy in reset", busy, 0);
    chk("R10 hold in reset", th_hold, 0);
    chk("R10 load in reset", load_stb, 0);
    chk("R10 result in reset", result, 0);
    chk("R10 awake in reset", core_awake, 1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R10 busy after release", busy, 0);
  endtask

  task automatic t_normal();
    run_conv(3'd5, 12'hA5C, 0, 0);
    raise_strobe();
    run_conv(3'd0, 12'h000, 0, 0);
    raise_strobe();
    run_conv(3'd7, 12'hFFF, 0, 0);
    raise_strobe();
    run_conv(3'd1, 12'h001, 0, 0);
    raise_strobe();
  endtask

  task automatic t_ignore();
    run_conv(3'd2, 12'h123, 1, 0);
    chk("R6 result kept from first start", result, {3'd2, 12'h123});
    raise_strobe();
  endtask

  task automatic t_burst();
    logic [14:0] keep;
    @(negedge clk);
    keep   = result;
    clk_en = 1'b0;
    #100;
    chk("R7 idle busy with clock stopped", busy, 0);
    chk("R7 idle result with clock stopped", result, keep);
    clk_en = 1'b1;
    run_conv(3'd6, 12'h7FE, 0, 1);
    raise_strobe();
  endtask

  task automatic t_auto();
    pwr_mode = 2'd2;
    @(negedge clk);
    chk("R8 awake before auto conversion", core_awake, 1);
    run_conv(3'd1, 12'h456, 0, 0);
    chk("R8 asleep after auto conversion", core_awake, 0);
    repeat (3) @(negedge clk);
    chk("R8 stays asleep", core_awake, 0);
    chk("R8 no conversion while asleep", busy, 0);
    conv_n = 1'b1;
    @(negedge clk);
    chk("R8 rising strobe wakes", core_awake, 1);
    chk("R8 wake does not convert", busy, 0);
    run_conv(3'd3, 12'h9AB, 0, 0);
    chk("R8 asleep again", core_awake, 0);
    pwr_mode = 2'd3;
    raise_strobe();
    @(negedge clk);
    chk("R8 standby wake", core_awake, 1);
    run_conv(3'd4, 12'h3C3, 0, 0);
    chk("R8 standby sleeps", core_awake, 0);
    raise_strobe();
  endtask

  task automatic t_full();
    @(negedge clk);
    pwr_mode = 2'd1;
    @(negedge clk);
    chk("R9 full shutdown not awake", core_awake, 0);
    conv_n = 1'b0;
    @(negedge clk);
    conv_n = 1'b1;
    @(negedge clk);
    conv_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R9 no conversion in full shutdown", busy, 0);
    chk("R9 still shut down", core_awake, 0);
    pwr_mode = 2'd0;
    @(negedge clk);
    chk("R9 normal mode clears sleep", core_awake, 1);
    raise_strobe();
    run_conv(3'd5, 12'h5A5, 0, 0);
    raise_strobe();
  endtask

  initial begin
    clk_en   = 1'b1;
    rst_n    = 1'b0;
    conv_n   = 1'b1;
    pwr_mode = 2'd0;
    ch_sel   = 3'd0;
    target   = 12'h000;
    t_reset();
    t_normal();
    t_ignore();
    t_burst();
    t_auto();
    t_full();
    repeat (2) @(negedge clk);
    fin = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #400000;
    if (!fin) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule